// File: doc/BRIEF.md
# Asynchronous Host Bus Register Interface

This block is the slave end of a strobe-based asynchronous microprocessor bus in a display controller. A host drives an active-low chip select, separate active-low write and read strobes, a register-select line and a data bus up to 18 bits wide. Through these lines it reaches three registers: a 16-bit index register, a write-data register and a read-data register. A completed data write is held in the write-data register. It is then offered on a commit port to either the control register file or the frame memory, depending on the index. Data reads return the read-data register, which is refilled from frame memory after each read. The first read after an index write therefore yields a dummy value.

The bus width is fixed by static mode pins: 18-bit, 16-bit, 9-bit and 8-bit. In the 9-bit and 8-bit modes, each word moves as two transfers. In the 8-bit mode, a separate pin chooses whether the high byte or the low byte goes first. The strobes, register select and bus pass through a multi-stage synchroniser. Each access takes effect once, on the trailing (rising) edge of its strobe. An internal frame-memory address counter steps by one after every frame-memory write commit and after every prefetch. The counter is loaded by a data write to a dedicated address index.

Top module: `hostbus_regif`

## Requirements
- R1: After reset, bus_oe, busy, cm_valid, mem_rd_req and overrun are all low.
- R2: A completed write with rs low loads the low 16 bits of the assembled word into the index register, and that index appears on cm_index for the following data writes. The same write zeroes the read-data register and clears any fetch still waiting.
- R3: A read with rs low drives the 16-bit status_word, zero-extended to 18 bits, through the same width mapping that data reads use.
- R4: A completed write with rs high raises cm_valid with cm_data equal to the assembled word. cm_mem is 1 exactly when the index equals MEM_IDX (default 0x0022), and then cm_addr is the current frame-memory address, which steps by one when the commit is accepted. A commit to index ADDR_IDX (default 0x0021) loads the address from cm_data[15:0] when accepted.
- R5: Each completed read with rs high returns the read-data register and then fetches the word at the current frame-memory address, stepping the address by one. So the first read after an index write returns 0, and later reads return consecutive memory words.
- R6: Mode 0 (width_sel=0) moves 18 bits on bus[17:0]. Mode 1 moves 16 bits on bus[15:0], with word bits 17:16 taken as 0 on writes and driven as 0 on reads.
- R7: Mode 2 (9-bit) moves a word as two transfers on bus[8:0]: first word[17:9], then word[8:0], for both writes and reads.
- R8: Mode 3 (8-bit) moves a 16-bit word as two bytes on bus[7:0], with word bits 17:16 zero. With hi_first=1 the order is word[15:8] then word[7:0]; with hi_first=0 it is the reverse.
- R9: In the narrow modes, a held first half is discarded when the next transfer differs from it in rs or in direction. That transfer becomes a new first half, so no word mixes halves from different accesses.
- R10: busy equals cm_valid, and cm_valid with its fields holds until cm_ready. A data write that completes while a commit is waiting and not accepted that cycle is dropped, and overrun pulses high for one cycle.
- R11: With cm_ready high, consecutive host writes need no wait states: each one produces its own commit.
- R12: An access counts only when cs_n is low and exactly one strobe is low. A pulse with both strobes low, or with cs_n high, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| rs | input | 1 | Register select: 0 index/status, 1 data |
| bus_in | input | 18 | Host data toward the block |
| bus_out | output | 18 | Data toward the host during reads |
| bus_oe | output | 1 | High while bus_out should be driven |
| width_sel | input | 2 | Static bus width: 0=18, 1=16, 2=9, 3=8 |
| hi_first | input | 1 | 8-bit mode byte order, 1 = high byte first |
| status_word | input | 16 | Internal status returned on status reads |
| cm_valid | output | 1 | Commit of a written word pending |
| cm_ready | input | 1 | Commit accepted this cycle |
| cm_mem | output | 1 | Commit targets frame memory (else register file) |
| cm_index | output | 16 | Index the commit belongs to |
| cm_addr | output | 16 | Frame-memory address for a memory commit |
| cm_data | output | 18 | Committed word |
| mem_rd_req | output | 1 | Frame-memory prefetch request |
| mem_rd_addr | output | 16 | Prefetch address |
| mem_rd_ack | input | 1 | Prefetch data valid, completes the request |
| mem_rd_data | input | 18 | Prefetch data |
| busy | output | 1 | Previous commit not yet accepted |
| overrun | output | 1 | One-cycle pulse: a write was dropped while busy |

## Verification
The bench targets the dummy read after an index write. A design that fetched on the index write, or did not zero the read register, would return real data on that first read and shift later reads by one word. Each width mode and both byte orders are written and read back. A swapped half or an unmasked upper field shows up as a wrong word. A dangling 8-bit half followed by an index write checks that the halves are not mixed. Holding cm_ready low during a second write checks that the first word survives, the second is dropped and overrun fires. Pulses with both strobes low or with chip select high check that no such pulse creates a commit.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int DW = 18;
    localparam int HW = 9;

    typedef enum logic [1:0] {
        BW18 = 2'd0,
        BW16 = 2'd1,
        BW9  = 2'd2,
        BW8  = 2'd3
    } bw_e;

    typedef logic [DW-1:0] word_t;
    typedef logic [HW-1:0] half_t;

    function automatic logic is_narrow(input bw_e m);
        return (m == BW9) || (m == BW8);
    endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/hb_pack.sv
module hb_pack
    import hb_pkg::*;
(
    input  bw_e   mode,
    input  logic  hi_first,
    input  half_t part,
    input  word_t bus,
    input  word_t src,
    input  logic  second,
    output word_t word,
    output half_t half,
    output word_t rd_bus
);
    logic sel_hi;

    always_comb begin
        half = (mode == BW9) ? bus[HW-1:0] : {1'b0, bus[7:0]};
        unique case (mode)
            BW18:    word = bus;
            BW16:    word = {2'b00, bus[15:0]};
            BW9:     word = {part, bus[HW-1:0]};
            default: word = hi_first ? {2'b00, part[7:0], bus[7:0]}
                                     : {2'b00, bus[7:0], part[7:0]};
        endcase
    end

    always_comb begin
        sel_hi = hi_first ^ second;
        unique case (mode)
            BW18:    rd_bus = src;
            BW16:    rd_bus = {2'b00, src[15:0]};
            BW9:     rd_bus = second ? {9'b0, src[8:0]} : {9'b0, src[17:9]};
            default: rd_bus = sel_hi ? {10'b0, src[15:8]} : {10'b0, src[7:0]};
        endcase
    end
endmodule

// File: rtl/hb_prefetch.sv
module hb_prefetch
    import hb_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          fetch,
    input  logic [AW-1:0] fetch_addr,
    output word_t         rdr,
    output logic          req,
    output logic [AW-1:0] req_addr,
    input  logic          ack,
    input  word_t         ack_data
);
    typedef struct packed {
        word_t         rdr;
        logic          req;
        logic [AW-1:0] raddr;
    } pf_t;

    pf_t pf_d, pf_q;

    always_comb begin
        pf_d = pf_q;
        if (pf_q.req && ack) begin
            pf_d.rdr = ack_data;
            pf_d.req = 1'b0;
        end
        if (fetch) begin
            pf_d.req   = 1'b1;
            pf_d.raddr = fetch_addr;
        end
        if (clear) begin
            pf_d.rdr = '0;
            pf_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pf_q <= '0;
        else        pf_q <= pf_d;
    end

    assign rdr      = pf_q.rdr;
    assign req      = pf_q.req;
    assign req_addr = pf_q.raddr;

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !clear && !fetch) |=> (req && $stable(req_addr)));

    // R2
    rdr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rdr == '0 && !req));
endmodule

// File: rtl/hostbus_regif.sv
module hostbus_regif
    import hb_pkg::*;
#(
    parameter int            AW          = 16,
    parameter int            IW          = 16,
    parameter logic [IW-1:0] MEM_IDX     = 'h0022,
    parameter logic [IW-1:0] ADDR_IDX    = 'h0021,
    parameter int            SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          rs,
    input  logic [17:0]   bus_in,
    output logic [17:0]   bus_out,
    output logic          bus_oe,
    input  logic [1:0]    width_sel,
    input  logic          hi_first,
    input  logic [15:0]   status_word,
    output logic          cm_valid,
    input  logic          cm_ready,
    output logic          cm_mem,
    output logic [IW-1:0] cm_index,
    output logic [AW-1:0] cm_addr,
    output logic [17:0]   cm_data,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_ack,
    input  logic [17:0]   mem_rd_data,
    output logic          busy,
    output logic          overrun
);
    localparam int SW = DW + 3;

    typedef struct packed {
        logic          wr_a;
        logic          rd_a;
        logic          rs;
        word_t         bus;
        logic          phase;
        logic          ph_rs;
        logic          ph_rd;
        half_t         part;
        logic [IW-1:0] idx;
        logic [AW-1:0] addr;
        logic          cm_v;
        logic          cm_mem;
        logic [IW-1:0] cm_idx;
        logic [AW-1:0] cm_addr;
        word_t         cm_data;
        logic          ovr;
        logic          oe;
        word_t         dout;
    } st_t;

    st_t st_d, st_q;

    bw_e           mode;
    logic [SW-1:0] sync_in, sync_out;
    logic          s_wr, s_rd, s_rs;
    word_t         s_bus;
    logic          wr_end, rd_end, acc, pair_done, narrow;
    word_t         wr_word, rd_bus, rd_src, rdr;
    half_t         half;
    logic          second_live;
    logic          clear_rdr, fetch, inc_c, inc_f, load;
    logic [AW-1:0] addr_base;

    assign mode = bw_e'(width_sel);
    assign narrow = is_narrow(mode);

    // access qualification: chip selected and exactly one strobe low
    assign sync_in = {rs, bus_in, ~cs_n & ~wr_n & rd_n, ~cs_n & ~rd_n & wr_n};

    hb_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_in),
        .q     (sync_out)
    );

    assign s_rd  = sync_out[0];
    assign s_wr  = sync_out[1];
    assign s_bus = sync_out[DW+1:2];
    assign s_rs  = sync_out[DW+2];

    assign wr_end = st_q.wr_a & ~s_wr;
    assign rd_end = st_q.rd_a & ~s_rd;
    assign acc    = wr_end | rd_end;
    assign pair_done = !narrow ||
                       (st_q.phase && (st_q.ph_rs == st_q.rs) && (st_q.ph_rd == rd_end));

    assign second_live = st_q.phase && st_q.ph_rd && (st_q.ph_rs == s_rs);
    assign rd_src      = s_rs ? rdr : {2'b00, status_word};

    hb_pack u_pack (
        .mode     (mode),
        .hi_first (hi_first),
        .part     (st_q.part),
        .bus      (st_q.bus),
        .src      (rd_src),
        .second   (second_live),
        .word     (wr_word),
        .half     (half),
        .rd_bus   (rd_bus)
    );

    hb_prefetch #(.AW(AW)) u_prefetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_rdr),
        .fetch      (fetch),
        .fetch_addr (addr_base),
        .rdr        (rdr),
        .req        (mem_rd_req),
        .req_addr   (mem_rd_addr),
        .ack        (mem_rd_ack),
        .ack_data   (mem_rd_data)
    );

    always_comb begin
        st_d      = st_q;
        clear_rdr = 1'b0;
        fetch     = 1'b0;
        inc_c     = 1'b0;
        inc_f     = 1'b0;
        load      = 1'b0;

        st_d.wr_a = s_wr;
        st_d.rd_a = s_rd;
        st_d.rs   = s_rs;
        st_d.bus  = s_bus;
        st_d.ovr  = 1'b0;

        // commit acceptance
        if (st_q.cm_v && cm_ready) begin
            st_d.cm_v = 1'b0;
            if (st_q.cm_mem)                  inc_c = 1'b1;
            else if (st_q.cm_idx == ADDR_IDX) load  = 1'b1;
        end
        addr_base = load ? st_q.cm_data[AW-1:0] : st_q.addr + AW'(inc_c);

        // trailing edge of an access
        if (acc) begin
            if (!pair_done) begin
                st_d.phase = 1'b1;
                st_d.ph_rs = st_q.rs;
                st_d.ph_rd = rd_end;
                st_d.part  = half;
            end else begin
                st_d.phase = 1'b0;
                if (wr_end && !st_q.rs) begin
                    st_d.idx  = wr_word[IW-1:0];
                    clear_rdr = 1'b1;
                end else if (wr_end) begin
                    if (st_q.cm_v && !cm_ready) begin
                        st_d.ovr = 1'b1;
                    end else begin
                        st_d.cm_v    = 1'b1;
                        st_d.cm_mem  = (st_q.idx == MEM_IDX);
                        st_d.cm_idx  = st_q.idx;
                        st_d.cm_addr = addr_base;
                        st_d.cm_data = wr_word;
                    end
                end else if (st_q.rs) begin
                    fetch = 1'b1;
                    inc_f = 1'b1;
                end
            end
        end
        st_d.addr = addr_base + AW'(inc_f);

        st_d.oe   = s_rd;
        st_d.dout = s_rd ? rd_bus : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_out  = st_q.dout;
    assign bus_oe   = st_q.oe;
    assign cm_valid = st_q.cm_v;
    assign cm_mem   = st_q.cm_mem;
    assign cm_index = st_q.cm_idx;
    assign cm_addr  = st_q.cm_addr;
    assign cm_data  = st_q.cm_data;
    assign busy     = st_q.cm_v;
    assign overrun  = st_q.ovr;

    // R10
    cm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_ready) |=> (cm_valid && $stable(cm_data) &&
                                     $stable(cm_index) && $stable(cm_addr) && $stable(cm_mem)));

    // R10
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(cm_valid && !cm_ready));

    // R10
    ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> !overrun);

    // R12
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));
endmodule

// File: tb/hostbus_regif_bench.sv
module hostbus_regif_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, rs = 1'b0;
    logic [17:0] bus_in = '0;
    logic [17:0] bus_out;
    logic        bus_oe;
    logic [1:0]  width_sel = 2'd0;
    logic        hi_first = 1'b1;
    logic [15:0] status_word = '0;
    logic        cm_valid, cm_ready = 1'b1, cm_mem;
    logic [15:0] cm_index, cm_addr, mem_rd_addr;
    logic [17:0] cm_data, mem_rd_data;
    logic        mem_rd_req, mem_rd_ack, busy, overrun;

    int n_tests = 0, n_fail = 0, n_cm = 0, n_ovr = 0;
    logic [17:0] bm [64];
    logic [17:0] last_data;
    logic [15:0] last_idx, last_addr;
    logic        last_mem;

    always #10 clk = ~clk;

    hostbus_regif u_hostbus_regif (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .rs(rs),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .width_sel(width_sel),
        .hi_first(hi_first), .status_word(status_word), .cm_valid(cm_valid),
        .cm_ready(cm_ready), .cm_mem(cm_mem), .cm_index(cm_index), .cm_addr(cm_addr),
        .cm_data(cm_data), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .busy(busy), .overrun(overrun)
    );

    assign mem_rd_ack  = mem_rd_req;
    assign mem_rd_data = bm[mem_rd_addr[5:0]];

    always @(posedge clk) begin
        if (cm_valid && cm_ready) begin
            n_cm      <= n_cm + 1;
            last_data <= cm_data;
            last_idx  <= cm_index;
            last_addr <= cm_addr;
            last_mem  <= cm_mem;
            if (cm_mem) bm[cm_addr[5:0]] <= cm_data;
        end
        if (overrun) n_ovr <= n_ovr + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer_wr(input logic r, input logic [17:0] v);
        @(negedge clk); cs_n = 1'b0; rs = r; bus_in = v; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1; bus_in = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic xfer_rd(input logic r, output logic [17:0] v);
        @(negedge clk); cs_n = 1'b0; rs = r; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        v = bus_out;
        rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic word_wr(input logic r, input logic [17:0] w);
        case (width_sel)
            2'd0, 2'd1: xfer_wr(r, w);
            2'd2: begin xfer_wr(r, {9'b0, w[17:9]}); xfer_wr(r, {9'b0, w[8:0]}); end
            default: begin
                if (hi_first) begin xfer_wr(r, {10'b0, w[15:8]}); xfer_wr(r, {10'b0, w[7:0]}); end
                else          begin xfer_wr(r, {10'b0, w[7:0]});  xfer_wr(r, {10'b0, w[15:8]}); end
            end
        endcase
    endtask

    task automatic word_rd(input logic r, output logic [17:0] w);
        logic [17:0] a, b;
        case (width_sel)
            2'd0: begin xfer_rd(r, a); w = a; end
            2'd1: begin xfer_rd(r, a); w = {2'b00, a[15:0]}; end
            2'd2: begin xfer_rd(r, a); xfer_rd(r, b); w = {a[8:0], b[8:0]}; end
            default: begin
                xfer_rd(r, a); xfer_rd(r, b);
                w = hi_first ? {2'b00, a[7:0], b[7:0]} : {2'b00, b[7:0], a[7:0]};
            end
        endcase
    endtask

    // {mode[2], hi_first[1], written word[18], expected stored/readback[18]}
    localparam logic [38:0] VEC [8] = '{
        {2'd0, 1'b0, 18'h2A5F3, 18'h2A5F3},
        {2'd0, 1'b0, 18'h1FFFF, 18'h1FFFF},
        {2'd1, 1'b0, 18'h3BEEF, 18'h0BEEF},
        {2'd1, 1'b0, 18'h01234, 18'h01234},
        {2'd2, 1'b0, 18'h3C0A5, 18'h3C0A5},
        {2'd2, 1'b0, 18'h00101, 18'h00101},
        {2'd3, 1'b1, 18'h1A55A, 18'h0A55A},
        {2'd3, 1'b0, 18'h0C3E1, 18'h0C3E1}
    };

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'd0, 2'd1: return "R6";
            2'd2:       return "R7";
            default:    return "R8";
        endcase
    endfunction

    initial begin
        logic [17:0] d;
        int base;
        for (int k = 0; k < 64; k++) bm[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs", {27'b0, bus_oe, busy, cm_valid, mem_rd_req, overrun}, 32'h0);

        // vector table: write through each mode, read back with dummy
        for (int i = 0; i < 8; i++) begin
            logic [1:0]  m;
            logic        hf;
            logic [17:0] w, e;
            {m, hf, w, e} = VEC[i];
            width_sel = m; hi_first = hf;
            word_wr(1'b0, 18'h00021); word_wr(1'b1, 18'(i));
            word_wr(1'b0, 18'h00022); word_wr(1'b1, w);
            chk({mode_req(m), " R4 commit data"}, {14'b0, last_data}, {14'b0, e});
            chk("R4 commit to memory at loaded address", {15'b0, last_mem, last_addr},
                {15'b0, 1'b1, 16'(i)});
            word_wr(1'b0, 18'h00021); word_wr(1'b1, 18'(i));
            word_wr(1'b0, 18'h00022);
            word_rd(1'b1, d);
            chk("R5 dummy read after index write", {14'b0, d}, 32'h0);
            word_rd(1'b1, d);
            chk({mode_req(m), " readback"}, {14'b0, d}, {14'b0, e});
        end

        // R5 consecutive reads with auto-increment
        width_sel = 2'd0;
        word_wr(1'b0, 18'h00021); word_wr(1'b1, 18'h0);
        word_wr(1'b0, 18'h00022);
        word_rd(1'b1, d); chk("R5 dummy", {14'b0, d}, 32'h0);
        word_rd(1'b1, d); chk("R5 word 0", {14'b0, d}, 32'h2A5F3);
        word_rd(1'b1, d); chk("R5 word 1", {14'b0, d}, 32'h1FFFF);

        // R3 status reads
        status_word = 16'hA5C3;
        word_rd(1'b0, d); chk("R3 status 18-bit", {14'b0, d}, 32'h0A5C3);
        width_sel = 2'd3; hi_first = 1'b1; status_word = 16'h5A3C;
        word_rd(1'b0, d); chk("R3 status 8-bit", {14'b0, d}, 32'h5A3C);

        // R2/R4 register write
        width_sel = 2'd0;
        word_wr(1'b0, 18'h30040); word_wr(1'b1, 18'h00777);
        chk("R2 index low 16 bits", {16'b0, last_idx}, 32'h0040);
        chk("R4 register commit", {13'b0, last_mem, last_data}, {13'b0, 1'b0, 18'h00777});

        // R11 back-to-back memory writes
        word_wr(1'b0, 18'h00021); word_wr(1'b1, 18'd20);
        word_wr(1'b0, 18'h00022);
        base = n_cm;
        word_wr(1'b1, 18'h11111); word_wr(1'b1, 18'h22222); word_wr(1'b1, 18'h33333);
        chk("R11 three commits", n_cm - base, 32'd3);
        chk("R11 last address", {16'b0, last_addr}, 32'd22);
        chk("R11 middle word stored", {14'b0, bm[21]}, 32'h22222);

        // R10 overrun
        cm_ready = 1'b0;
        base = n_cm;
        word_wr(1'b1, 18'h0ABCD);
        chk("R10 busy while waiting", {31'b0, busy}, 32'd1);
        word_wr(1'b1, 18'h0DCBA);
        chk("R10 overrun pulse count", n_ovr, 32'd1);
        @(negedge clk); cm_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 one commit kept", n_cm - base, 32'd1);
        chk("R10 first word kept", {14'b0, last_data}, 32'h0ABCD);
        chk("R10 busy cleared", {31'b0, busy}, 32'd0);

        // R9 dangling half discarded by index write (8-bit, high first)
        width_sel = 2'd3; hi_first = 1'b1;
        xfer_wr(1'b1, 18'h000EE);
        word_wr(1'b0, 18'h00040);
        word_wr(1'b1, 18'h01234);
        chk("R9 index not mixed", {16'b0, last_idx}, 32'h0040);
        chk("R9 data not mixed", {14'b0, last_data}, 32'h01234);

        // R12 illegal strobe combinations
        width_sel = 2'd0;
        base = n_cm;
        @(negedge clk); cs_n = 1'b0; rs = 1'b1; bus_in = 18'h3FFFF; wr_n = 1'b0; rd_n = 1'b0;
        repeat (3) @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
        @(negedge clk); cs_n = 1'b1; repeat (5) @(negedge clk);
        chk("R12 both strobes low ignored", n_cm - base, 32'd0);
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b0;
        repeat (3) @(negedge clk); wr_n = 1'b1; repeat (5) @(negedge clk);
        chk("R12 deselected write ignored", n_cm - base, 32'd0);
        chk("R12 no read drive", {31'b0, bus_oe}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule